// File: doc/BRIEF.md
# Interval and Pulse-Counting Down-Timer

This block is a 16-bit down-counter with an 8-bit holding register for its low byte. It is programmed through two byte-wide register selects on a small bus. One select stages the low byte. The other supplies the high byte and loads the full count at once. A mode input picks its time base. In interval mode the counter steps on every clock enable. In pulse mode it steps on each falling edge of an already-synchronised input, so software can count external events.

When the count steps below zero after a load, the block raises a one-cycle flag-set pulse for an interrupt collector and sets its own flag. The flag fires once per load. Later wraps stay silent until the high byte is written again. Reading the low byte clears the flag, and so does a fresh load. The first step after a load is swallowed. In pulse mode the low byte reads back one less than the stored count whenever that byte is nonzero.

Top module: `pulse_timer`

## Requirements
- R1: After reset the counter reads 0xFFFF (select 9 returns 0xFF, select 8 returns 0xFF in interval mode), the low-byte holding register holds 0xFF, and `flag_o` is 0.
- R2: A write to select 8 changes only the holding register. The counter value and the flag are untouched, and the new byte reaches the counter at the next select 9 write.
- R3: A write to select 9 loads the counter with the written byte as bits 15:8 and the holding register as bits 7:0. In the cycle after the write `flag_o` is 0, and the block is re-armed so that the next underflow sets the flag again.
- R4: The first step opportunity after a select 9 write leaves the counter unchanged. Each later opportunity decrements it by one.
- R5: With `mode_i` = 0 (interval), each clock with `en_i` = 1 is a step opportunity, and `pulse_i` has no effect.
- R6: With `mode_i` = 1 (pulse), a step opportunity is a clock at which `pulse_i` is 0 after being 1 on the previous clock. `en_i` has no effect.
- R7: A step taken at count 0 while armed wraps the counter to 0xFFFF, drives `flag_set_o` high for that one cycle and sets `flag_o`. Further wraps before the next select 9 write raise neither.
- R8: A read of select 8 clears `flag_o` at the following clock, unless a flag-set event occurs in that same cycle.
- R9: In pulse mode a select 8 read returns the counter low byte minus one when that byte is nonzero, and 0x00 when it is zero. In interval mode it returns the low byte unchanged.
- R10: A select 9 read returns counter bits 15:8. `rdata_o` is combinational from `rd_i` and `addr_i`.
- R11: Accesses to any select other than 8 and 9 change no state, and reads of them return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clock enable used as the interval time base |
| mode_i | input | 1 | 0 = interval timing, 1 = pulse counting |
| pulse_i | input | 1 | Synchronised event input, counted on falling edges |
| addr_i | input | 4 | Register select |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| flag_set_o | output | 1 | One-cycle pulse when the interrupt flag is set |
| flag_o | output | 1 | Interrupt flag |

## Verification
The bound checker watches the per-cycle rules on every clock: a select 9 load and its clearing of the flag, the holding-register update, the frozen count in the cycle after a load, the wrap to 0xFFFF and flag set that follow an underflow pulse, and the clear caused by a low-byte read. Whether an underflow fires only once per load across a full 65536-step wrap, the minus-one read adjustment in pulse mode, the falling-edge qualification of the event input, and the silence of unused selects only show up in the bench's scenarios, through values read back on the bus.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  typedef enum logic {
    TMODE_INTERVAL = 1'b0,
    TMODE_PULSE    = 1'b1
  } tmode_e;

  localparam int unsigned BYTE_W_DEF = 8;
  localparam int unsigned ADDR_W_DEF = 4;
endpackage

// File: rtl/ptmr_fall_det.sv
module ptmr_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic fall_o
);
  logic in_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_q <= 1'b0;
    else         in_q <= in_i;
  end

  assign fall_o = in_q & ~in_i;
endmodule

// File: rtl/ptmr_core.sv
module ptmr_core #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lo_wr_i,
  input  logic              hi_wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              step_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [BYTE_W-1:0] latch_o,
  output logic              uflow_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] latch_q;
  logic              skip_q;
  logic              armed_q;
  logic              take_step;

  // a load in the same cycle overrides any step
  assign take_step = step_i & ~skip_q & ~hi_wr_i;
  assign uflow_o   = take_step & armed_q & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '1;
      latch_q <= '1;
      skip_q  <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      if (lo_wr_i) latch_q <= wdata_i;
      if (hi_wr_i) begin
        cnt_q   <= {wdata_i, latch_q};
        skip_q  <= 1'b1;
        armed_q <= 1'b1;
      end else if (step_i) begin
        if (skip_q) begin
          skip_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == '0) armed_q <= 1'b0;
        end
      end
    end
  end

  assign cnt_o   = cnt_q;
  assign latch_o = latch_q;
endmodule

// File: rtl/ptmr_rd_mux.sv
module ptmr_rd_mux #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = 2 * BYTE_W
) (
  input  logic              rd_lo_i,
  input  logic              rd_hi_i,
  input  ptmr_pkg::tmode_e  mode_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [BYTE_W-1:0] rdata_o
);
  logic [BYTE_W-1:0] lo_byte;
  logic [BYTE_W-1:0] lo_view;

  assign lo_byte = cnt_i[BYTE_W-1:0];

  always_comb begin
    lo_view = lo_byte;
    if (mode_i == ptmr_pkg::TMODE_PULSE && lo_byte != '0)
      lo_view = lo_byte - 1'b1;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_lo_i)      rdata_o = lo_view;
    else if (rd_hi_i) rdata_o = cnt_i[CNT_W-1:BYTE_W];
  end
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer #(
  parameter int unsigned BYTE_W = ptmr_pkg::BYTE_W_DEF,
  parameter int unsigned ADDR_W = ptmr_pkg::ADDR_W_DEF,
  parameter int unsigned LO_SEL = 8,
  parameter int unsigned HI_SEL = 9,
  localparam int unsigned CNT_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              mode_i,
  input  logic              pulse_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              flag_set_o,
  output logic              flag_o
);
  ptmr_pkg::tmode_e  mode;
  logic              sel_lo, sel_hi;
  logic              lo_wr, hi_wr, lo_rd, hi_rd;
  logic              fall, step, uflow;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] latch;
  logic              flag_q;

  assign mode   = ptmr_pkg::tmode_e'(mode_i);
  assign sel_lo = (addr_i == ADDR_W'(LO_SEL));
  assign sel_hi = (addr_i == ADDR_W'(HI_SEL));
  assign lo_wr  = wr_i & sel_lo;
  assign hi_wr  = wr_i & sel_hi;
  assign lo_rd  = rd_i & sel_lo;
  assign hi_rd  = rd_i & sel_hi;

  ptmr_fall_det u_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (pulse_i),
    .fall_o (fall)
  );

  assign step = (mode == ptmr_pkg::TMODE_PULSE) ? fall : en_i;

  ptmr_core #(.BYTE_W(BYTE_W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lo_wr_i (lo_wr),
    .hi_wr_i (hi_wr),
    .wdata_i (wdata_i),
    .step_i  (step),
    .cnt_o   (cnt),
    .latch_o (latch),
    .uflow_o (uflow)
  );

  ptmr_rd_mux #(.BYTE_W(BYTE_W)) u_rd (
    .rd_lo_i (lo_rd),
    .rd_hi_i (hi_rd),
    .mode_i  (mode),
    .cnt_i   (cnt),
    .rdata_o (rdata_o)
  );

  // a set in the same cycle as a clear wins, so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              flag_q <= 1'b0;
    else if (uflow)           flag_q <= 1'b1;
    else if (lo_rd || hi_wr)  flag_q <= 1'b0;
  end

  assign flag_set_o = uflow;
  assign flag_o     = flag_q;
endmodule

// File: rtl/pulse_timer_chk.sv
module pulse_timer_chk #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = 2 * BYTE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lo_wr_i,
  input logic              hi_wr_i,
  input logic              lo_rd_i,
  input logic [BYTE_W-1:0] wdata_i,
  input logic              uflow_i,
  input logic              flag_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [BYTE_W-1:0] latch_i
);
  // R2
  latch_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_wr_i |=> latch_i == $past(wdata_i));

  // R3
  hi_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_wr_i |=> (cnt_i == {$past(wdata_i), $past(latch_i)}) && !flag_i);

  // R4
  first_step_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_wr_i ##1 !hi_wr_i |=> $stable(cnt_i));

  // R7
  uflow_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uflow_i |=> flag_i);

  // R7
  uflow_wraps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uflow_i |=> cnt_i == '1);

  // R8
  lo_read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_rd_i && !uflow_i |=> !flag_i);
endmodule

bind pulse_timer pulse_timer_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .lo_wr_i (lo_wr),
  .hi_wr_i (hi_wr),
  .lo_rd_i (lo_rd),
  .wdata_i (wdata_i),
  .uflow_i (uflow),
  .flag_i  (flag_q),
  .cnt_i   (cnt),
  .latch_i (latch)
);

// File: tb/pulse_timer_tb.sv
`timescale 1ns/100ps
module pulse_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, mode = 1'b0, pulse = 1'b0;
  logic [3:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       flag_set, flag;

  int checks = 0;
  int fails  = 0;
  int sets   = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pulse_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode), .pulse_i(pulse),
    .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata),
    .flag_set_o(flag_set), .flag_o(flag)
  );

  // flag-set pulse counter, sampled mid-cycle
  always @(negedge clk) begin
    #1;
    if (rst_n && flag_set) sets++;
  end

  typedef struct packed {
    logic       md;
    logic [7:0] lo;
    logic [7:0] hi;
    logic [7:0] n;
    logic [7:0] exp_hi;
    logic [7:0] exp_lo;
    logic       exp_flag;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h0A, 8'h00, 8'd0, 8'h00, 8'h0A, 1'b0},  // R3 load
    '{1'b0, 8'h0A, 8'h00, 8'd1, 8'h00, 8'h0A, 1'b0},  // R4 skip
    '{1'b0, 8'h0A, 8'h00, 8'd5, 8'h00, 8'h06, 1'b0},  // R5
    '{1'b0, 8'h00, 8'h01, 8'd3, 8'h00, 8'hFE, 1'b0},  // R5 borrow
    '{1'b0, 8'h00, 8'h00, 8'd2, 8'hFF, 8'hFF, 1'b1},  // R7
    '{1'b1, 8'h05, 8'h01, 8'd3, 8'h01, 8'h02, 1'b0},  // R9 minus one
    '{1'b1, 8'h02, 8'h00, 8'd3, 8'h00, 8'h00, 1'b0},  // R9 zero
    '{1'b1, 8'h00, 8'h00, 8'd2, 8'hFF, 8'hFE, 1'b1},  // R6 R7
    '{1'b0, 8'h34, 8'h12, 8'd0, 8'h12, 8'h34, 1'b0}   // R10
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    en = 1'b1;
    repeat (n) @(negedge clk);
    en = 1'b0;
  endtask

  task automatic pulses(input int n);
    repeat (n) begin
      pulse = 1'b1; @(negedge clk);
      pulse = 1'b0; @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    chk("R1 flag in reset", {15'd0, flag}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd_reg(4'd9, d); chk("R1 hi", {8'd0, d}, 16'h00FF);
    rd_reg(4'd8, d); chk("R1 lo", {8'd0, d}, 16'h00FF);
    chk("R1 flag", {15'd0, flag}, 16'd0);
    wr_reg(4'd9, 8'h00);
    rd_reg(4'd8, d); chk("R1 latch", {8'd0, d}, 16'h00FF);

    // vector table
    for (int i = 0; i < NV; i++) begin
      mode = VECS[i].md;
      wr_reg(4'd8, VECS[i].lo);
      wr_reg(4'd9, VECS[i].hi);
      if (VECS[i].md) pulses(int'(VECS[i].n));
      else            ticks(int'(VECS[i].n));
      rd_reg(4'd9, d); chk($sformatf("vec%0d R10 hi", i), {8'd0, d}, {8'd0, VECS[i].exp_hi});
      chk($sformatf("vec%0d R7 flag", i), {15'd0, flag}, {15'd0, VECS[i].exp_flag});
      rd_reg(4'd8, d); chk($sformatf("vec%0d R9 lo", i), {8'd0, d}, {8'd0, VECS[i].exp_lo});
      chk($sformatf("vec%0d R8 cleared", i), {15'd0, flag}, 16'd0);
    end
    mode = 1'b0;

    // R2 low write leaves counter alone
    wr_reg(4'd8, 8'h34); wr_reg(4'd9, 8'h12);
    wr_reg(4'd8, 8'h56);
    rd_reg(4'd9, d); chk("R2 hi kept", {8'd0, d}, 16'h0012);
    rd_reg(4'd8, d); chk("R2 lo kept", {8'd0, d}, 16'h0034);
    wr_reg(4'd9, 8'h00);
    rd_reg(4'd8, d); chk("R2 latch used", {8'd0, d}, 16'h0056);

    // R6 en ignored in pulse mode; R5 pulse ignored in interval mode
    mode = 1'b1;
    wr_reg(4'd8, 8'h10); wr_reg(4'd9, 8'h00);
    en = 1'b1; repeat (5) @(negedge clk); en = 1'b0;
    rd_reg(4'd8, d); chk("R6 en ignored", {8'd0, d}, 16'h000F);
    pulses(2);
    rd_reg(4'd8, d); chk("R6 falling edges", {8'd0, d}, 16'h000E);
    mode = 1'b0;
    wr_reg(4'd8, 8'h10); wr_reg(4'd9, 8'h00);
    pulses(3);
    rd_reg(4'd8, d); chk("R5 pulse ignored", {8'd0, d}, 16'h0010);

    // R7 single fire per load across a full wrap, R3 re-arm
    wr_reg(4'd8, 8'h00); wr_reg(4'd9, 8'h00);
    sets = 0;
    ticks(2);
    chk("R7 one pulse", sets[15:0], 16'd1);
    rd_reg(4'd8, d);
    ticks(65536);
    chk("R7 no refire pulse", sets[15:0], 16'd1);
    chk("R7 no refire flag", {15'd0, flag}, 16'd0);
    rd_reg(4'd9, d); chk("R7 wrapped", {8'd0, d}, 16'h00FF);
    wr_reg(4'd9, 8'h00);
    ticks(2);
    chk("R3 rearmed", sets[15:0], 16'd2);
    chk("R3 flag set again", {15'd0, flag}, 16'd1);
    wr_reg(4'd9, 8'h00);
    chk("R3 write clears flag", {15'd0, flag}, 16'd0);

    // R11 other selects
    wr_reg(4'd8, 8'h21); wr_reg(4'd9, 8'h43);
    wr_reg(4'd3, 8'h77);
    rd_reg(4'd3, d); chk("R11 read zero", {8'd0, d}, 16'h0000);
    rd_reg(4'd9, d); chk("R11 hi kept", {8'd0, d}, 16'h0043);
    rd_reg(4'd8, d); chk("R11 lo kept", {8'd0, d}, 16'h0021);
    wr_reg(4'd9, 8'h00);
    rd_reg(4'd8, d); chk("R11 latch kept", {8'd0, d}, 16'h0021);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule